// File: doc/BRIEF.md
# Variable-Width Stack Push/Pop Unit

This unit carries out stack transfers of one, two or four bytes against a byte-addressed internal data memory. It also swaps an accumulator value with a memory byte, either the whole byte or only its low nibble. An 8-bit stack pointer lives inside the unit and is driven on a port. Operand values enter on plain ports, and pop results and new accumulator values leave on a plain result port.

A request is presented with `req_valid` and is taken on a rising clock edge where `req_ready` is also high. `req_ready` is high exactly when the unit is idle. While an operation runs, `req_ready` stays low, and whatever is on the request port is ignored: the requester must hold its request until `req_ready` returns. Each operation signals completion with a one-cycle `done` pulse. The pulse comes a fixed number of cycles after acceptance. That number is looked up from the operation form, the operand size and the latency-table select. Port and peripheral targets of single-byte moves and direct exchanges add extra cycles.

Memory reads are combinational: `mem_rdata` must reflect `mem_addr` in the same cycle. A write happens on the clock edge that ends a cycle in which `mem_we` is high.

Top module: `stack_xfer_unit`

## Requirements
- R1: After reset, `sp` reads 0x07, `done` is low and `req_ready` is high.
- R2: Push (`req_op`=0) adds one to `sp` on the accepting edge. It then writes the operand to ascending addresses, starting at that new pointer, with the most significant byte first. Afterwards it adds size minus one, so `sp` ends on the last byte written (start + size). `res_data` reads zero at `done`.
- R3: Pop (`req_op`=1) subtracts size minus one from `sp` on the accepting edge. It then reads ascending addresses, with the lowest address as the most significant byte, and afterwards subtracts one (final `sp` = start − size). `res_data` holds the value zero-extended at `done`.
- R4: `req_size` 0 moves 1 byte (`req_data[7:0]`), 1 moves 2 bytes (`req_data[15:0]`), and 2 or 3 moves 4 bytes.
- R5: `sp` arithmetic wraps modulo 256 with no flag, including multi-byte transfers that cross address 0xFF/0x00.
- R6: Byte exchange (`req_op`=2) writes `req_acc` to `mem[req_addr]` and returns the old memory byte in `res_data[7:0]`. `sp` does not change.
- R7: Nibble exchange (`req_op`=3) swaps bits 3:0 of the accumulator with bits 3:0 of `mem[req_addr]` and keeps both upper nibbles. The new accumulator appears in `res_data[7:0]`.
- R8: With `alt_mode`=0, the latency (cycles from accepting edge to `done`) is as follows. Byte push: 2. Byte pop: 3. Word push/pop: 5. Double-word push/pop: 9. Exchange with register (`req_form`=0): 3. Exchange with direct address (`req_form`=1): 3. Exchange with indirect operand (`req_form`≥2): 4. Nibble exchange (any form): 4.
- R9: `req_target` 1 (I/O port) adds 1 cycle and 2 (peripheral) adds 2 cycles to byte push/pop. For direct exchanges, 1 adds 2 cycles and 2 adds 3 cycles. Target 0 or 3 adds nothing, and multi-byte moves ignore the target.
- R10: With `alt_mode`=1, word push/pop take 4, double-word push/pop take 8, exchange with register takes 4, and indirect/nibble exchanges take 5. All other entries are unchanged.
- R11: `done` is high for exactly one cycle. `req_ready` is low from acceptance until the `done` cycle and high in it. Requests presented while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_mode | input | 1 | Selects the alternate latency table; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; request taken when both are high |
| req_op | input | 2 | 0 push, 1 pop, 2 byte exchange, 3 nibble exchange |
| req_size | input | 2 | 0 byte, 1 word, 2/3 double word (push/pop only) |
| req_form | input | 2 | Exchange operand: 0 register, 1 direct, 2/3 indirect |
| req_target | input | 2 | 0 RAM, 1 I/O port, 2 peripheral register, 3 RAM |
| req_addr | input | 8 | Memory address of the exchange operand |
| req_data | input | 32 | Push operand, right-aligned |
| req_acc | input | 8 | Accumulator value for exchanges |
| mem_addr | output | 8 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, combinational on `mem_addr` |
| sp | output | 8 | Stack pointer |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | 32 | Pop value or new accumulator; valid at `done` |

## Verification
The bench targets these corner cases:
- **Split pointer steps.** `sp` is checked in the cycle right after acceptance, separately from its final value. A unit that moved the pointer only at the end, or by the full size up front, fails there.
- **Byte order.** A word and a double word are pushed and then popped back, so a reversed byte order shows up both in memory and in `res_data`.
- **Latency.** Each latency entry, the target surcharges and the alternate table are run with `done` compared every cycle, so an off-by-one in the counter or a surcharge applied to the wrong form is caught.
- **Wrap and busy.** Pops and pushes that cross 0x00/0xFF expose missing modulo wrap. A request held high through a busy window would, if wrongly accepted, disturb the pointer and memory.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int SP_W      = 8;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 4;
  localparam int DATA_W    = BYTE_W * MAX_BYTES;
  localparam int LANE_W    = $clog2(MAX_BYTES);
  localparam int STEP_W    = LANE_W + 1;
  localparam int LAT_W     = 4;

  // latency table entries (cycles from acceptance to done)
  localparam int LAT_PUSH_B    = 2;
  localparam int LAT_POP_B     = 3;
  localparam int LAT_WORD_STD  = 5;
  localparam int LAT_WORD_ALT  = 4;
  localparam int LAT_DWORD_STD = 9;
  localparam int LAT_DWORD_ALT = 8;
  localparam int LAT_XREG_STD  = 3;
  localparam int LAT_XREG_ALT  = 4;
  localparam int LAT_XDIR      = 3;
  localparam int LAT_XIND_STD  = 4;
  localparam int LAT_XIND_ALT  = 5;
  localparam int EXT_MV_PORT   = 1;
  localparam int EXT_MV_PERIPH = 2;
  localparam int EXT_XC_PORT   = 2;
  localparam int EXT_XC_PERIPH = 3;

  typedef enum logic [1:0] {OP_PUSH = 2'd0, OP_POP = 2'd1, OP_XCH = 2'd2, OP_XCHD = 2'd3} op_e;
  typedef enum logic [1:0] {FM_REG = 2'd0, FM_DIR = 2'd1, FM_IND = 2'd2, FM_IND2 = 2'd3} form_e;
  typedef enum logic [1:0] {TG_RAM = 2'd0, TG_PORT = 2'd1, TG_PERIPH = 2'd2, TG_RAM2 = 2'd3} tgt_e;

  function automatic logic [STEP_W-1:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return STEP_W'(1);
      2'd1:    return STEP_W'(2);
      default: return STEP_W'(MAX_BYTES);
    endcase
  endfunction
endpackage

// File: rtl/stk_lat.sv
module stk_lat
  import stk_pkg::*;
#(
  parameter int CNT_W = LAT_W
) (
  input  op_e              op,
  input  logic [1:0]       size,
  input  form_e            form,
  input  tgt_e             tgt,
  input  logic             alt,
  output logic [CNT_W-1:0] lat
);
  int ext_mv;
  int ext_xc;
  int val;

  always_comb begin
    ext_mv = 0;
    ext_xc = 0;
    if (tgt == TG_PORT) begin
      ext_mv = EXT_MV_PORT;
      ext_xc = EXT_XC_PORT;
    end else if (tgt == TG_PERIPH) begin
      ext_mv = EXT_MV_PERIPH;
      ext_xc = EXT_XC_PERIPH;
    end
    val = 0;
    case (op)
      OP_PUSH, OP_POP: begin
        if (size == 2'd0)      val = ((op == OP_PUSH) ? LAT_PUSH_B : LAT_POP_B) + ext_mv;
        else if (size == 2'd1) val = alt ? LAT_WORD_ALT : LAT_WORD_STD;
        else                   val = alt ? LAT_DWORD_ALT : LAT_DWORD_STD;
      end
      OP_XCH: begin
        if (form == FM_REG)      val = alt ? LAT_XREG_ALT : LAT_XREG_STD;
        else if (form == FM_DIR) val = LAT_XDIR + ext_xc;
        else                     val = alt ? LAT_XIND_ALT : LAT_XIND_STD;
      end
      default: val = alt ? LAT_XIND_ALT : LAT_XIND_STD;
    endcase
    lat = CNT_W'(val);
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] lat,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= lat;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R11
endmodule

// File: rtl/stk_dp.sv
module stk_dp
  import stk_pkg::*;
#(
  parameter logic [SP_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  op_e               req_op,
  input  logic [1:0]        req_size,
  input  logic [SP_W-1:0]   req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [BYTE_W-1:0] req_acc,
  output logic [SP_W-1:0]   mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [SP_W-1:0]   sp,
  output logic [DATA_W-1:0] res_data
);
  logic [BYTE_W-1:0] req_lane [MAX_BYTES];
  logic [STEP_W-1:0] req_n;
  logic [DATA_W-1:0] push_aligned;

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_lane
    assign req_lane[b] = req_data[BYTE_W*b +: BYTE_W];
  end

  assign req_n = size_bytes(req_size);

  // most significant operand byte goes to the top lane, sent first
  always_comb begin
    push_aligned = '0;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (STEP_W'(i) < req_n)
        push_aligned[DATA_W-BYTE_W*(i+1) +: BYTE_W] = req_lane[LANE_W'(int'(req_n) - 1 - i)];
    end
  end

  op_e               op_q;
  logic [STEP_W-1:0] nst_q;
  logic [STEP_W-1:0] step_q;
  logic [SP_W-1:0]   base_q;
  logic [SP_W-1:0]   xaddr_q;
  logic [SP_W-1:0]   sp_q;
  logic [SP_W-1:0]   sp_start_q;
  logic [DATA_W-1:0] data_q;
  logic [BYTE_W-1:0] acc_q;

  logic is_move, is_exch, xfer, last;
  logic [BYTE_W-1:0] new_acc;

  assign is_move = (op_q == OP_PUSH) || (op_q == OP_POP);
  assign is_exch = !is_move;
  assign xfer    = busy && (step_q < nst_q);
  assign last    = xfer && (step_q == nst_q - STEP_W'(1));
  assign new_acc = (op_q == OP_XCHD) ? {acc_q[BYTE_W-1:4], data_q[3:0]} : data_q[BYTE_W-1:0];

  always_comb begin
    mem_addr  = is_move ? (base_q + SP_W'(step_q)) : xaddr_q;
    mem_we    = xfer && ((op_q == OP_PUSH) || (is_exch && step_q == STEP_W'(1)));
    mem_re    = xfer && ((op_q == OP_POP)  || (is_exch && step_q == STEP_W'(0)));
    case (op_q)
      OP_PUSH: mem_wdata = data_q[DATA_W-1 -: BYTE_W];
      OP_XCHD: mem_wdata = {data_q[BYTE_W-1:4], acc_q[3:0]};
      default: mem_wdata = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q       <= OP_PUSH;
      nst_q      <= '0;
      step_q     <= '0;
      base_q     <= '0;
      xaddr_q    <= '0;
      sp_q       <= SP_RESET;
      sp_start_q <= SP_RESET;
      data_q     <= '0;
      acc_q      <= '0;
    end else if (start) begin
      op_q       <= req_op;
      step_q     <= '0;
      sp_start_q <= sp_q;
      xaddr_q    <= req_addr;
      acc_q      <= req_acc;
      case (req_op)
        OP_PUSH: begin
          nst_q  <= req_n;
          sp_q   <= sp_q + SP_W'(1);
          base_q <= sp_q + SP_W'(1);
          data_q <= push_aligned;
        end
        OP_POP: begin
          nst_q  <= req_n;
          sp_q   <= sp_q - SP_W'(req_n - STEP_W'(1));
          base_q <= sp_q - SP_W'(req_n - STEP_W'(1));
          data_q <= '0;
        end
        default: begin
          nst_q  <= STEP_W'(2);
          data_q <= '0;
        end
      endcase
    end else if (xfer) begin
      step_q <= step_q + STEP_W'(1);
      case (op_q)
        OP_PUSH: begin
          data_q <= data_q << BYTE_W;
          if (last) sp_q <= sp_q + SP_W'(nst_q - STEP_W'(1));
        end
        OP_POP: begin
          data_q <= {data_q[DATA_W-BYTE_W-1:0], mem_rdata};
          if (last) sp_q <= sp_q - SP_W'(1);
        end
        default: begin
          if (step_q == STEP_W'(0)) data_q <= {{(DATA_W-BYTE_W){1'b0}}, mem_rdata};
          else                      data_q <= {{(DATA_W-BYTE_W){1'b0}}, new_acc};
        end
      endcase
    end
  end

  assign sp       = sp_q;
  assign res_data = data_q;

  AST_PUSH_SP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer && op_q == OP_PUSH) |-> (sp_q == sp_start_q + SP_W'(nst_q))); // R2
  AST_POP_SP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer && op_q == OP_POP) |-> (sp_q == sp_start_q - SP_W'(nst_q))); // R3
  AST_XCH_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_exch) |-> (sp_q == sp_start_q)); // R6
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R7
endmodule

// File: rtl/stack_xfer_unit.sv
module stack_xfer_unit
  import stk_pkg::*;
#(
  parameter logic [7:0] SP_RESET = 8'h07,
  parameter int         CNT_W    = LAT_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alt_mode,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic [1:0]  req_size,
  input  logic [1:0]  req_form,
  input  logic [1:0]  req_target,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_data,
  input  logic [7:0]  req_acc,
  output logic [7:0]  mem_addr,
  output logic        mem_we,
  output logic        mem_re,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  sp,
  output logic        done,
  output logic [31:0] res_data
);
  logic             busy;
  logic             start;
  logic [CNT_W-1:0] lat;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  stk_lat #(.CNT_W(CNT_W)) u_lat (
    .op   (op_e'(req_op)),
    .size (req_size),
    .form (form_e'(req_form)),
    .tgt  (tgt_e'(req_target)),
    .alt  (alt_mode),
    .lat  (lat)
  );

  stk_seq #(.CNT_W(CNT_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .lat   (lat),
    .busy  (busy),
    .done  (done)
  );

  stk_dp #(.SP_RESET(SP_RESET)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .req_op    (op_e'(req_op)),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_acc   (req_acc),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .sp        (sp),
    .res_data  (res_data)
  );

  AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_we && !mem_re)); // R8
endmodule

// File: tb/stack_xfer_unit_bench.sv
module stack_xfer_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, alt_mode, req_valid, req_ready;
  logic [1:0] req_op, req_size, req_form, req_target;
  logic [7:0] req_addr, req_acc, mem_addr, mem_wdata, mem_rdata, sp;
  logic [31:0] req_data, res_data;
  logic mem_we, mem_re, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_xfer_unit u_stack_xfer_unit (
    .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_size(req_size), .req_form(req_form), .req_target(req_target),
    .req_addr(req_addr), .req_data(req_data), .req_acc(req_acc), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .sp(sp), .done(done), .res_data(res_data)
  );

  logic [7:0] bmem [256];
  logic [7:0] rmem [256];
  logic [7:0] rsp;
  int total = 0;
  int bad = 0;

  always @(posedge clk) if (mem_we) bmem[mem_addr] <= mem_wdata;
  assign mem_rdata = bmem[mem_addr];

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int ref_lat(input int op, input int size, input int form, input int tgt, input bit alt);
    int e1 = (tgt == 1) ? 1 : (tgt == 2) ? 2 : 0;
    int e2 = (tgt == 1) ? 2 : (tgt == 2) ? 3 : 0;
    if (op <= 1) begin
      if (size == 0) return (op == 0 ? 2 : 3) + e1;
      if (size == 1) return alt ? 4 : 5;
      return alt ? 8 : 9;
    end
    if (op == 2 && form == 0) return alt ? 4 : 3;
    if (op == 2 && form == 1) return 3 + e2;
    return alt ? 5 : 4;
  endfunction

  task automatic run_op(input int op, input int size, input int form, input int tgt,
                        input logic [7:0] addr, input logic [31:0] data, input logic [7:0] acc,
                        input bit alt, input string ltag, input bit noise);
    int L, n;
    logic [7:0] mid, m, a;
    logic [31:0] exp_res;
    string ptag;
    bit same;
    L = ref_lat(op, size, form, tgt, alt);
    n = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    exp_res = 32'h0;
    ptag = (op == 0) ? "R2" : (op == 1) ? "R3" : "R6";
    case (op)
      0: begin
        mid = rsp + 8'd1;
        for (int i = 0; i < n; i++) begin
          a = mid + 8'(i);
          rmem[a] = data[8*(n-1-i) +: 8];
        end
        rsp = mid + 8'(n - 1);
      end
      1: begin
        mid = rsp - 8'(n - 1);
        for (int i = 0; i < n; i++) begin
          a = mid + 8'(i);
          exp_res = {exp_res[23:0], rmem[a]};
        end
        rsp = mid - 8'd1;
      end
      2: begin
        mid = rsp;
        m = rmem[addr];
        rmem[addr] = acc;
        exp_res = {24'h0, m};
      end
      default: begin
        mid = rsp;
        m = rmem[addr];
        rmem[addr] = {m[7:4], acc[3:0]};
        exp_res = {24'h0, acc[7:4], m[3:0]};
      end
    endcase
    alt_mode = alt; req_op = 2'(op); req_size = 2'(size); req_form = 2'(form);
    req_target = 2'(tgt); req_addr = addr; req_data = data; req_acc = acc; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R11", "ready before request", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    if (noise) begin
      req_op = 2'd0; req_size = 2'd2; req_data = 32'hFFFF_FFFF; req_acc = 8'h00; req_addr = 8'h00;
    end else req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11", "ready while busy", req_ready, 0);
    chk(sp == mid, ptag, "sp after accepting edge", sp, mid);
    for (int k = 1; k <= L + 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == L - 1) req_valid = 1'b0;
      chk(done == (k == L), ltag, $sformatf("done in cycle %0d of %0d", k, L), done, (k == L));
      if (k < L) chk(req_ready == 1'b0, "R11", "ready low while busy", req_ready, 0);
      if (k == L) begin
        chk(req_ready == 1'b1, "R11", "ready at done", req_ready, 1);
        chk(sp == rsp, ptag, "final sp", sp, rsp);
        chk(res_data == exp_res, (op == 3) ? "R7" : ptag, "result", res_data, exp_res);
        same = 1'b1;
        for (int j = 0; j < 256; j++) if (bmem[j] !== rmem[j]) same = 1'b0;
        chk(same, (op == 3) ? "R7" : ptag, "memory image", same, 1);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < 256; j++) begin
      bmem[j] = 8'(j * 7 + 3);
      rmem[j] = 8'(j * 7 + 3);
    end
    rst_n = 1'b0; alt_mode = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_size = 2'd0;
    req_form = 2'd0; req_target = 2'd0; req_addr = 8'h0; req_data = 32'h0; req_acc = 8'h0;
    rsp = 8'h07;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sp == 8'h07, "R1", "reset sp", sp, 8'h07);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);

    // R8 R9 byte pushes to each target class
    run_op(0, 0, 1, 0, 8'h00, 32'h0000_00A5, 8'h00, 0, "R8", 0);
    run_op(0, 0, 1, 1, 8'h00, 32'h0000_005A, 8'h00, 0, "R9", 0);
    run_op(0, 0, 1, 2, 8'h00, 32'h0000_00C3, 8'h00, 0, "R9", 0);
    run_op(0, 0, 1, 3, 8'h00, 32'h0000_0077, 8'h00, 0, "R9", 0);
    // R4 word and double-word push, target ignored
    run_op(0, 1, 0, 2, 8'h00, 32'hFFFF_1234, 8'h00, 0, "R4", 0);
    run_op(0, 2, 0, 1, 8'h00, 32'hDEAD_BEEF, 8'h00, 0, "R8", 0);
    run_op(1, 2, 0, 0, 8'h00, 32'h0, 8'h00, 0, "R8", 0);
    // R10 alternate table
    run_op(0, 3, 0, 0, 8'h00, 32'h0102_0304, 8'h00, 1, "R10", 0);
    run_op(1, 1, 0, 0, 8'h00, 32'h0, 8'h00, 1, "R10", 0);
    run_op(1, 1, 0, 0, 8'h00, 32'h0, 8'h00, 0, "R8", 0);
    run_op(1, 0, 1, 0, 8'h00, 32'h0, 8'h00, 0, "R8", 0);
    run_op(1, 0, 1, 1, 8'h00, 32'h0, 8'h00, 1, "R9", 0);
    run_op(1, 0, 1, 2, 8'h00, 32'h0, 8'h00, 0, "R9", 0);
    // R6 byte exchange forms
    run_op(2, 0, 0, 0, 8'h40, 32'h0, 8'h9C, 0, "R8", 0);
    run_op(2, 0, 0, 0, 8'h41, 32'h0, 8'h11, 1, "R10", 0);
    run_op(2, 0, 1, 1, 8'h42, 32'h0, 8'h22, 0, "R9", 0);
    run_op(2, 0, 1, 2, 8'h43, 32'h0, 8'h33, 1, "R9", 0);
    run_op(2, 0, 2, 0, 8'h44, 32'h0, 8'h44, 0, "R8", 0);
    run_op(2, 0, 3, 0, 8'h45, 32'h0, 8'h55, 1, "R10", 0);
    // R7 nibble exchange
    run_op(3, 0, 2, 0, 8'h50, 32'h0, 8'hA6, 0, "R8", 0);
    run_op(3, 0, 0, 1, 8'h51, 32'h0, 8'h5F, 1, "R10", 0);
    // R11 request held during busy window is ignored
    run_op(0, 1, 0, 0, 8'h00, 32'h0000_BEAD, 8'h00, 0, "R11", 1);
    run_op(2, 0, 1, 0, 8'h60, 32'h0, 8'h0F, 0, "R11", 1);
    // R5 wrap below zero and across 0xFF
    for (int r = 0; r < 4; r++) run_op(1, 2, 0, 0, 8'h00, 32'h0, 8'h00, 0, "R5", 0);
    run_op(0, 2, 0, 0, 8'h00, 32'hCAFE_F00D, 8'h00, 0, "R5", 0);
    run_op(0, 2, 0, 0, 8'h00, 32'h8765_4321, 8'h00, 1, "R5", 0);
    run_op(1, 2, 0, 0, 8'h00, 32'h0, 8'h00, 0, "R5", 0);
    run_op(1, 1, 0, 0, 8'h00, 32'h0, 8'h00, 0, "R5", 0);
    run_op(1, 0, 1, 0, 8'h00, 32'h0, 8'h00, 0, "R5", 0);
    run_op(1, 0, 1, 0, 8'h00, 32'h0, 8'h00, 0, "R5", 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule